// File: doc/BRIEF.md
# Compare and Trap Condition Unit

This unit takes two operands and evaluates every ordering relation between them at once. A compare instruction uses the result to write a 4-bit condition field. A trap instruction uses it to decide whether a trap-type program exception should be requested. A single 5-bit relation vector is built per operation and both instruction families draw on it. Compares pick three of its bits. Traps AND it with a 5-bit condition mask and reduce the result with an OR.

Operand B comes either from a register or from a 16-bit immediate that is sign-extended. A width select restricts the comparison to the low word. A signedness select chooses which half of the relation vector a compare reports. Results are registered: the condition field and its destination index show up one cycle after an accepted compare, and the trap request is a one-cycle pulse one cycle after an accepted trap.

Top module: `cmp_trap_unit`

## Requirements
- R1: While rst_ni is low and after its release with no accepted operation, cr_valid_o, cr_field_o, cr_idx_o and trap_o are all zero.
- R2: A signed compare (op_trap_i=0, is_signed_i=1) accepted with valid_i=1 raises cr_valid_o for the next cycle. In that cycle cr_field_o[3]=LT, cr_field_o[2]=GT and cr_field_o[1]=EQ, all taken from the signed relations of A and B.
- R3: An unsigned compare (is_signed_i=0) fills cr_field_o[3:1] the same way, taken from the unsigned relations.
- R4: With is_32bit_i=1 only bits 31:0 of each operand are compared. They are sign-extended for the signed relations and zero-extended for the unsigned ones.
- R5: With b_is_reg_i=0, operand B is imm_i sign-extended from 16 bits and opb_i has no effect. With b_is_reg_i=1, operand B is opb_i.
- R6: For a trap (op_trap_i=1), the mask bits to_mask_i[4:0] select in order: signed less-than, signed greater-than, equal, unsigned less-than, unsigned greater-than. trap_o is 1 in the cycle after acceptance exactly when some selected relation holds.
- R7: A trap with to_mask_i=5'b00000 never raises trap_o. A trap with to_mask_i=5'b11111 always raises it.
- R8: A compare never raises trap_o. A trap leaves cr_valid_o low and leaves cr_field_o and cr_idx_o unchanged. A cycle with valid_i=0 raises neither output.
- R9: cr_field_o[0] is the so_i value sampled with the compare, and cr_idx_o is the crf_idx_i value sampled with it.
- R10: trap_o is high for exactly one cycle per accepted trap that fires. Traps that fire on consecutive cycles give consecutive high cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_trap_i | input | 1 | 1 = trap, 0 = compare |
| is_signed_i | input | 1 | Compare reports signed relations |
| is_32bit_i | input | 1 | Compare low 32 bits only |
| b_is_reg_i | input | 1 | Operand B from register (1) or immediate (0) |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Register operand B |
| imm_i | input | 16 | Immediate operand B, sign-extended |
| to_mask_i | input | 5 | Trap condition mask |
| crf_idx_i | input | 3 | Destination condition field index |
| so_i | input | 1 | Summary overflow copied into the field |
| cr_valid_o | output | 1 | Condition field written this cycle |
| cr_field_o | output | 4 | {LT, GT, EQ, SO} |
| cr_idx_o | output | 3 | Destination field index |
| trap_o | output | 1 | Trap request pulse |

## Verification
Compare and trap results leave through the same register stage. A trap and a compare can therefore be in flight on adjacent cycles, and the output of one overlaps the acceptance of the other. The bench issues a firing trap immediately followed by a compare, and separately two firing traps back to back. In each output cycle it checks that only the output belonging to that operation is active: trap_o without cr_valid_o, then cr_valid_o without trap_o carrying the new field. It also checks that a trap does not disturb the condition field held from an earlier compare.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  localparam int unsigned REL_W  = 5;
  localparam int unsigned WORD_W = 32;

  // order matters: trap mask bit positions decode against it
  typedef struct packed {
    logic slt;
    logic sgt;
    logic eq;
    logic ult;
    logic ugt;
  } rel_vec_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_field_t;
endpackage

// File: rtl/ctu_operand_sel.sv
module ctu_operand_sel #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IMM_W = 16
) (
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  opb_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             b_is_reg_i,
  input  logic             is_32bit_i,
  output logic [XLEN-1:0]  a_s_o,
  output logic [XLEN-1:0]  b_s_o,
  output logic [XLEN-1:0]  a_u_o,
  output logic [XLEN-1:0]  b_u_o
);
  import ctu_pkg::*;

  localparam int unsigned EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] b_full;

  assign b_full = b_is_reg_i ? opb_i : {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

  generate
    if (XLEN > WORD_W) begin : g_narrow
      localparam int unsigned HI_W = XLEN - WORD_W;
      always_comb begin
        if (is_32bit_i) begin
          a_s_o = {{HI_W{opa_i[WORD_W-1]}},  opa_i[WORD_W-1:0]};
          b_s_o = {{HI_W{b_full[WORD_W-1]}}, b_full[WORD_W-1:0]};
          a_u_o = {{HI_W{1'b0}}, opa_i[WORD_W-1:0]};
          b_u_o = {{HI_W{1'b0}}, b_full[WORD_W-1:0]};
        end else begin
          a_s_o = opa_i;
          b_s_o = b_full;
          a_u_o = opa_i;
          b_u_o = b_full;
        end
      end
    end else begin : g_flat
      assign a_s_o = opa_i;
      assign b_s_o = b_full;
      assign a_u_o = opa_i;
      assign b_u_o = b_full;
    end
  endgenerate
endmodule

// File: rtl/ctu_relation.sv
module ctu_relation #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]     a_s_i,
  input  logic [XLEN-1:0]     b_s_i,
  input  logic [XLEN-1:0]     a_u_i,
  input  logic [XLEN-1:0]     b_u_i,
  output ctu_pkg::rel_vec_t   rel_o
);
  logic [XLEN:0] diff;
  logic          borrow;
  logic          sign_diff;
  logic          equal;

  // one subtractor serves both orderings
  assign diff      = {1'b0, a_u_i} - {1'b0, b_u_i};
  assign borrow    = diff[XLEN];
  assign equal     = (a_u_i == b_u_i);
  assign sign_diff = a_s_i[XLEN-1] ^ b_s_i[XLEN-1];

  always_comb begin
    rel_o.eq  = equal;
    rel_o.ult = borrow;
    rel_o.ugt = !borrow && !equal;
    // differing signs: the negative one is smaller; else unsigned order holds
    rel_o.slt = sign_diff ? a_s_i[XLEN-1] : borrow;
    rel_o.sgt = sign_diff ? b_s_i[XLEN-1] : (!borrow && !equal);
  end
endmodule

// File: rtl/ctu_result.sv
module ctu_result #(
  parameter int unsigned CRF_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              op_trap_i,
  input  logic              is_signed_i,
  input  logic              so_i,
  input  logic [4:0]        to_mask_i,
  input  logic [CRF_W-1:0]  crf_idx_i,
  input  ctu_pkg::rel_vec_t rel_i,
  output logic              cr_valid_o,
  output logic [3:0]        cr_field_o,
  output logic [CRF_W-1:0]  cr_idx_o,
  output logic              trap_o
);
  import ctu_pkg::*;

  cr_field_t        cr_next;
  cr_field_t        cr_q;
  logic             hit;
  logic             cmp_go;
  logic             trap_go;
  logic [CRF_W-1:0] idx_q;
  logic             cr_valid_q;
  logic             trap_q;

  always_comb begin
    cr_next.lt = is_signed_i ? rel_i.slt : rel_i.ult;
    cr_next.gt = is_signed_i ? rel_i.sgt : rel_i.ugt;
    cr_next.eq = rel_i.eq;
    cr_next.so = so_i;
  end

  assign hit     = |(rel_i & to_mask_i);
  assign cmp_go  = valid_i && !op_trap_i;
  assign trap_go = valid_i && op_trap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr_valid_q <= 1'b0;
      trap_q     <= 1'b0;
      cr_q       <= '0;
      idx_q      <= '0;
    end else begin
      cr_valid_q <= cmp_go;
      trap_q     <= trap_go && hit;
      if (cmp_go) begin
        cr_q  <= cr_next;
        idx_q <= crf_idx_i;
      end
    end
  end

  assign cr_valid_o = cr_valid_q;
  assign cr_field_o = cr_q;
  assign cr_idx_o   = idx_q;
  assign trap_o     = trap_q;

  assert_mask_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_go && to_mask_i == 5'b00000) |=> !trap_o);
  assert_mask_ones_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_go && to_mask_i == 5'b11111) |=> trap_o);
  assert_trap_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(valid_i && op_trap_i));
  assert_field_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_go |=> ($stable(cr_field_o) && $stable(cr_idx_o)));
  assert_so_idx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_go |=> (cr_field_o[0] == $past(so_i) && cr_idx_o == $past(crf_idx_i)));
endmodule

// File: rtl/cmp_trap_unit.sv
module cmp_trap_unit #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IMM_W = 16,
  parameter int unsigned CRF_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             op_trap_i,
  input  logic             is_signed_i,
  input  logic             is_32bit_i,
  input  logic             b_is_reg_i,
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  opb_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [4:0]       to_mask_i,
  input  logic [CRF_W-1:0] crf_idx_i,
  input  logic             so_i,
  output logic             cr_valid_o,
  output logic [3:0]       cr_field_o,
  output logic [CRF_W-1:0] cr_idx_o,
  output logic             trap_o
);
  import ctu_pkg::*;

  logic [XLEN-1:0] a_s, b_s, a_u, b_u;
  rel_vec_t        rel;

  ctu_operand_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opsel (
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .imm_i      (imm_i),
    .b_is_reg_i (b_is_reg_i),
    .is_32bit_i (is_32bit_i),
    .a_s_o      (a_s),
    .b_s_o      (b_s),
    .a_u_o      (a_u),
    .b_u_o      (b_u)
  );

  ctu_relation #(.XLEN(XLEN)) u_rel (
    .a_s_i (a_s),
    .b_s_i (b_s),
    .a_u_i (a_u),
    .b_u_i (b_u),
    .rel_o (rel)
  );

  ctu_result #(.CRF_W(CRF_W)) u_res (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .op_trap_i   (op_trap_i),
    .is_signed_i (is_signed_i),
    .so_i        (so_i),
    .to_mask_i   (to_mask_i),
    .crf_idx_i   (crf_idx_i),
    .rel_i       (rel),
    .cr_valid_o  (cr_valid_o),
    .cr_field_o  (cr_field_o),
    .cr_idx_o    (cr_idx_o),
    .trap_o      (trap_o)
  );

  assert_signed_rel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({rel.slt, rel.sgt, rel.eq}) == 1);
  assert_unsigned_rel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({rel.ult, rel.ugt, rel.eq}) == 1);
  assert_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_o && cr_valid_o));
  assert_cmp_no_trap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_trap_i) |=> !trap_o);
endmodule

// File: tb/tb_cmp_trap_unit.sv
module tb_cmp_trap_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, op_trap_i = 1'b0, is_signed_i = 1'b0;
  logic        is_32bit_i = 1'b0, b_is_reg_i = 1'b1, so_i = 1'b0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic [15:0] imm_i = '0;
  logic [4:0]  to_mask_i = '0;
  logic [2:0]  crf_idx_i = '0;
  logic        cr_valid_o, trap_o;
  logic [3:0]  cr_field_o;
  logic [2:0]  cr_idx_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  cmp_trap_unit dut (.*);

  typedef struct packed {
    logic        trap;
    logic        sgn;
    logic        w32;
    logic        breg;
    logic [63:0] a;
    logic [63:0] b;
    logic [15:0] imm;
    logic [4:0]  mask;
    logic [2:0]  cr;
    logic        trp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0,1'b1,64'hFFFFFFFFFFFFFFFF,64'h1,16'h0,5'h00,3'b100,1'b0},
    '{1'b0,1'b0,1'b0,1'b1,64'hFFFFFFFFFFFFFFFF,64'h1,16'h0,5'h00,3'b010,1'b0},
    '{1'b0,1'b1,1'b0,1'b1,64'h5,64'h5,16'h0,5'h00,3'b001,1'b0},
    '{1'b0,1'b1,1'b1,1'b1,64'h0000000180000000,64'h0,16'h0,5'h00,3'b100,1'b0},
    '{1'b0,1'b0,1'b1,1'b1,64'hFFFFFFFF00000005,64'h7,16'h0,5'h00,3'b100,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,64'hFFFFFFFFFFFFFFFD,64'h64,16'hFFFE,5'h00,3'b100,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,64'h10,64'h20,16'h0008,5'h00,3'b010,1'b0},
    '{1'b1,1'b0,1'b0,1'b1,64'hFFFFFFFFFFFFFFFF,64'h1,16'h0,5'b10000,3'b000,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,64'hFFFFFFFFFFFFFFFF,64'h1,16'h0,5'b00001,3'b000,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,64'hFFFFFFFFFFFFFFFF,64'h1,16'h0,5'b01010,3'b000,1'b0},
    '{1'b1,1'b0,1'b1,1'b0,64'h0000000100000003,64'h0,16'h0003,5'b00100,3'b000,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,64'h0000000100000003,64'h0,16'h0003,5'b00100,3'b000,1'b0},
    '{1'b1,1'b0,1'b0,1'b1,64'h9,64'h9,16'h0,5'b00000,3'b000,1'b0},
    '{1'b1,1'b0,1'b0,1'b1,64'h7,64'h9,16'h0,5'b11111,3'b000,1'b1},
    '{1'b1,1'b0,1'b1,1'b1,64'hFFFFFFFF7FFFFFFF,64'h0000000080000000,16'h0,5'b01000,3'b000,1'b1}
  };

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(logic trap, logic sgn, logic w32, logic breg, logic [63:0] a,
                       logic [63:0] b, logic [15:0] imm, logic [4:0] mask,
                       logic [2:0] idx, logic so);
    valid_i = 1'b1; op_trap_i = trap; is_signed_i = sgn; is_32bit_i = w32;
    b_is_reg_i = breg; opa_i = a; opb_i = b; imm_i = imm; to_mask_i = mask;
    crf_idx_i = idx; so_i = so;
  endtask

  task automatic idle();
    valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #3;
    chk("R1", "cr_valid in reset", {63'b0, cr_valid_o}, 64'd0);
    chk("R1", "trap in reset", {63'b0, trap_o}, 64'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "outputs after reset", {56'b0, cr_valid_o, trap_o, cr_field_o, cr_idx_o}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      vec_t v;
      v = TBL[i];
      if (v.trap) tag = (v.mask == 5'h00 || v.mask == 5'h1f) ? "R7" : "R6";
      else if (v.w32) tag = "R4";
      else if (!v.breg) tag = "R5";
      else tag = v.sgn ? "R2" : "R3";
      issue(v.trap, v.sgn, v.w32, v.breg, v.a, v.b, v.imm, v.mask, 3'(i), 1'b0);
      @(negedge clk_i);
      idle();
      if (v.trap) begin
        chk(tag, $sformatf("entry %0d trap", i), {63'b0, trap_o}, {63'b0, v.trp});
        chk("R8", $sformatf("entry %0d cr_valid", i), {63'b0, cr_valid_o}, 64'd0);
      end else begin
        chk(tag, $sformatf("entry %0d field", i), {60'b0, cr_field_o}, {60'b0, v.cr, 1'b0});
        chk(tag, $sformatf("entry %0d cr_valid", i), {63'b0, cr_valid_o}, 64'd1);
        chk("R8", $sformatf("entry %0d trap", i), {63'b0, trap_o}, 64'd0);
      end
      @(negedge clk_i);
    end

    // R9: SO and index carried
    issue(1'b0, 1'b1, 1'b0, 1'b1, 64'h3, 64'h3, 16'h0, 5'h0, 3'd5, 1'b1);
    @(negedge clk_i); idle();
    chk("R9", "field with so", {60'b0, cr_field_o}, 64'h3);
    chk("R9", "index", {61'b0, cr_idx_o}, 64'd5);
    @(negedge clk_i);

    // R8: trap leaves field and index alone; idle mask-ones does nothing
    issue(1'b1, 1'b0, 1'b0, 1'b1, 64'h1, 64'h2, 16'h0, 5'h1f, 3'd2, 1'b0);
    @(negedge clk_i); idle();
    chk("R8", "field kept over trap", {60'b0, cr_field_o}, 64'h3);
    chk("R8", "index kept over trap", {61'b0, cr_idx_o}, 64'd5);
    valid_i = 1'b0; op_trap_i = 1'b1; to_mask_i = 5'h1f;
    @(negedge clk_i);
    chk("R8", "idle trap", {63'b0, trap_o}, 64'd0);
    chk("R8", "idle cr_valid", {63'b0, cr_valid_o}, 64'd0);

    // R10: back-to-back firing traps, then pulse ends
    issue(1'b1, 1'b0, 1'b0, 1'b1, 64'h4, 64'h4, 16'h0, 5'b00100, 3'd0, 1'b0);
    @(negedge clk_i);
    chk("R10", "first trap", {63'b0, trap_o}, 64'd1);
    issue(1'b1, 1'b0, 1'b0, 1'b1, 64'h1, 64'h4, 16'h0, 5'b00010, 3'd0, 1'b0);
    @(negedge clk_i); idle();
    chk("R10", "second trap", {63'b0, trap_o}, 64'd1);
    @(negedge clk_i);
    chk("R10", "pulse ends", {63'b0, trap_o}, 64'd0);

    // R8: trap then compare on adjacent cycles
    issue(1'b1, 1'b0, 1'b0, 1'b1, 64'h8, 64'h2, 16'h0, 5'b01000, 3'd0, 1'b0);
    @(negedge clk_i);
    chk("R8", "adjacent trap", {62'b0, trap_o, cr_valid_o}, 64'b10);
    issue(1'b0, 1'b0, 1'b0, 1'b1, 64'h2, 64'h8, 16'h0, 5'h1f, 3'd7, 1'b0);
    @(negedge clk_i); idle();
    chk("R8", "adjacent compare", {62'b0, trap_o, cr_valid_o}, 64'b01);
    chk("R3", "adjacent compare field", {57'b0, cr_idx_o, cr_field_o}, {57'b0, 3'd7, 4'b1000});
    @(negedge clk_i);
    chk("R8", "after adjacent", {62'b0, trap_o, cr_valid_o}, 64'd0);

    finish_run();
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule